// File: doc/BRIEF.md
# Register Rename Unit with FIFO Free List

This block turns the architectural register names of one micro-op per cycle into physical register names. Each micro-op brings up to three source slots and up to two destination slots, and every slot has its own valid bit. Each valid source is translated through a map table. Each valid destination gets two results: a freshly allocated physical register, and the mapping it replaces. The replaced mapping goes with the micro-op and is returned when the micro-op retires. The condition flags are treated as one more architectural register, index 49, so they are renamed exactly like any other register.

The rename side is a valid/ready stream. A micro-op is accepted in a cycle where `rn_valid` and `rn_ready` are both high. The translations on the output pins are combinational and refer to the micro-op now on the input. They are meaningful only in a cycle where the micro-op is accepted. A source may hold `rn_valid` high with `rn_ready` low for as long as needed, and nothing in the block changes while it waits. The commit port has no back-pressure: it returns up to two freed registers per cycle, and those are appended to the tail of the free list.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i for i = 0..49. The free list holds physical registers 50 to NUM_PHYS-1 in ascending order, so the first allocation after reset returns 50.
- R2: For each source slot with its valid bit set, `rn_src_phys` gives the current map entry of that architectural register. A source slot whose valid bit is clear outputs 0.
- R3: For each valid destination slot, `rn_dst_old` gives the mapping that is being replaced and `rn_dst_new` gives the register taken from the head of the free list. From the next cycle, the map entry holds the new register. An invalid destination slot outputs 0 on both ports and takes no register.
- R4: Within one micro-op, every source sees the map as it was before the micro-op. Destination slot 0 is served before slot 1. When both slots name the same register, slot 1's old mapping is slot 0's new register, and slot 1's register stays in the map. When only slot 1 is valid, it takes the head of the free list.
- R5: Architectural register 49 holds the flags and is renamed and read like any other register.
- R6: Registers leave the free list in the order they entered it. A return in commit slot 0 enters before a return in commit slot 1 of the same cycle.
- R7: When `cm_valid` is high, each commit slot with its valid bit set appends `cm_free_phys` of that slot to the free list. When `cm_valid` is low, the commit port has no effect.
- R8: `rn_ready` is high exactly when the free list holds at least as many registers as the incoming micro-op has valid destinations. A micro-op that is not accepted, because `rn_valid` or `rn_ready` is low, changes neither the map nor the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | A micro-op is offered for renaming |
| rn_ready | output | 1 | Enough free registers for the offered micro-op |
| rn_src_arch | input | 3x6 | Architectural source registers, one field per slot |
| rn_src_vld | input | 3 | Valid bit of each source slot |
| rn_dst_arch | input | 2x6 | Architectural destination registers |
| rn_dst_vld | input | 2 | Valid bit of each destination slot |
| rn_src_phys | output | 3x6 | Translated source registers |
| rn_dst_new | output | 2x6 | Newly allocated destination registers |
| rn_dst_old | output | 2x6 | Replaced mappings, to be freed at commit |
| cm_valid | input | 1 | Commit port strobe |
| cm_free_vld | input | 2 | Valid bit of each returned register |
| cm_free_phys | input | 2x6 | Registers returned to the free list |

## Verification
A corrupted map entry shows up only when that architectural register is read next, either as a source or as the old mapping of a destination. The bench therefore reads back, in later micro-ops, every register it has renamed. A pointer or count error in the free list shows up at the next allocation: a register number arrives out of order, or `rn_ready` takes the wrong level. Because the free list is strictly first-in first-out, every allocation can be predicted exactly, so the bench checks allocations cycle by cycle, including when the list is drained to empty and refilled through the commit port.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned SRC_SLOTS  = 3;
  localparam int unsigned DST_SLOTS  = 2;
  localparam int unsigned FLAGS_AREG = 49;

  // number of set bits in a destination-slot valid mask
  function automatic logic [1:0] slot_count(input logic [DST_SLOTS-1:0] v);
    logic [1:0] n;
    n = '0;
    for (int i = 0; i < int'(DST_SLOTS); i++) n = n + {1'b0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
  import rn_pkg::*;
#(
  parameter int unsigned NUM_ARCH = 50,
  parameter int unsigned AW       = 6,
  parameter int unsigned PW       = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [SRC_SLOTS-1:0][AW-1:0]      src_arch,
  output logic [SRC_SLOTS-1:0][PW-1:0]      src_map,
  input  logic [DST_SLOTS-1:0][AW-1:0]      dst_arch,
  output logic [DST_SLOTS-1:0][PW-1:0]      dst_map,
  input  logic [DST_SLOTS-1:0]              wr_en,
  input  logic [DST_SLOTS-1:0][PW-1:0]      wr_phys
);
  logic [PW-1:0] map_q [NUM_ARCH];

  function automatic logic [PW-1:0] lookup(input logic [AW-1:0] a);
    logic [PW-1:0] r;
    r = '0;
    for (int k = 0; k < int'(NUM_ARCH); k++)
      if (int'(a) == k) r = map_q[k];
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < int'(SRC_SLOTS); i++) src_map[i] = lookup(src_arch[i]);
    for (int j = 0; j < int'(DST_SLOTS); j++) dst_map[j] = lookup(dst_arch[j]);
  end

  // later destination slot wins on equal architectural register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(NUM_ARCH); k++) map_q[k] <= PW'(k);
    end else begin
      for (int j = 0; j < int'(DST_SLOTS); j++)
        for (int k = 0; k < int'(NUM_ARCH); k++)
          if (wr_en[j] && int'(dst_arch[j]) == k) map_q[k] <= wr_phys[j];
    end
  end

  // R3
  map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[DST_SLOTS-1] && int'(dst_arch[DST_SLOTS-1]) < int'(NUM_ARCH))
      |=> lookup($past(dst_arch[DST_SLOTS-1])) == $past(wr_phys[DST_SLOTS-1]));
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
  import rn_pkg::*;
#(
  parameter int unsigned NUM_PHYS = 64,
  parameter int unsigned NUM_ARCH = 50,
  parameter int unsigned PW       = 6,
  localparam int unsigned DEPTH   = NUM_PHYS - NUM_ARCH,
  localparam int unsigned IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW      = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   pop_cnt,
  output logic [DST_SLOTS-1:0][PW-1:0] head,
  output logic [CW-1:0]                count,
  input  logic [DST_SLOTS-1:0]         push_vld,
  input  logic [DST_SLOTS-1:0][PW-1:0] push_phys
);
  logic [PW-1:0] mem_q [DEPTH];
  logic [IW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    push_n;
  logic [PW-1:0] push_first;

  function automatic logic [IW-1:0] adv(input logic [IW-1:0] p, input logic [1:0] n);
    int s;
    s = int'(p) + int'(n);
    if (s >= int'(DEPTH)) s = s - int'(DEPTH);
    return IW'(s);
  endfunction

  assign head[0]    = mem_q[rd_q];
  assign head[1]    = mem_q[adv(rd_q, 2'd1)];
  assign count      = cnt_q;
  assign push_n     = slot_count(push_vld);
  assign push_first = push_vld[0] ? push_phys[0] : push_phys[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(DEPTH); k++) mem_q[k] <= PW'(NUM_ARCH + k);
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(DEPTH);
    end else begin
      if (push_n != 2'd0) mem_q[wr_q] <= push_first;
      if (push_n == 2'd2) mem_q[adv(wr_q, 2'd1)] <= push_phys[1];
      rd_q  <= adv(rd_q, pop_cnt);
      wr_q  <= adv(wr_q, push_n);
      cnt_q <= CW'(int'(cnt_q) + int'(push_n) - int'(pop_cnt));
    end
  end

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_cnt) <= int'(cnt_q));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) + int'(push_n) - int'(pop_cnt) <= int'(DEPTH));
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rn_pkg::*;
#(
  parameter int unsigned NUM_PHYS = 64,
  parameter int unsigned NUM_ARCH = FLAGS_AREG + 1,
  localparam int unsigned AW      = $clog2(NUM_ARCH),
  localparam int unsigned PW      = $clog2(NUM_PHYS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rn_valid,
  output logic                          rn_ready,
  input  logic [SRC_SLOTS-1:0][AW-1:0]  rn_src_arch,
  input  logic [SRC_SLOTS-1:0]          rn_src_vld,
  input  logic [DST_SLOTS-1:0][AW-1:0]  rn_dst_arch,
  input  logic [DST_SLOTS-1:0]          rn_dst_vld,
  output logic [SRC_SLOTS-1:0][PW-1:0]  rn_src_phys,
  output logic [DST_SLOTS-1:0][PW-1:0]  rn_dst_new,
  output logic [DST_SLOTS-1:0][PW-1:0]  rn_dst_old,
  input  logic                          cm_valid,
  input  logic [DST_SLOTS-1:0]          cm_free_vld,
  input  logic [DST_SLOTS-1:0][PW-1:0]  cm_free_phys
);
  localparam int unsigned CW = $clog2(NUM_PHYS - NUM_ARCH + 1);

  logic [SRC_SLOTS-1:0][PW-1:0] src_map;
  logic [DST_SLOTS-1:0][PW-1:0] dst_map;
  logic [DST_SLOTS-1:0][PW-1:0] fl_head;
  logic [CW-1:0]                fl_count;
  logic [1:0]                   need;
  logic                         fire;
  logic [DST_SLOTS-1:0]         wr_en;

  assign need     = slot_count(rn_dst_vld);
  assign rn_ready = int'(fl_count) >= int'(need);
  assign fire     = rn_valid && rn_ready;
  assign wr_en    = fire ? rn_dst_vld : '0;

  generate
    for (genvar g = 0; g < int'(SRC_SLOTS); g++) begin : g_src
      assign rn_src_phys[g] = rn_src_vld[g] ? src_map[g] : '0;
    end
  endgenerate

  // slot 0 takes the head; slot 1 takes the next entry only if slot 0 took one
  always_comb begin
    rn_dst_new[0] = rn_dst_vld[0] ? fl_head[0] : '0;
    rn_dst_old[0] = rn_dst_vld[0] ? dst_map[0] : '0;
    rn_dst_new[1] = '0;
    rn_dst_old[1] = '0;
    if (rn_dst_vld[1]) begin
      rn_dst_new[1] = rn_dst_vld[0] ? fl_head[1] : fl_head[0];
      rn_dst_old[1] = (rn_dst_vld[0] && rn_dst_arch[0] == rn_dst_arch[1])
                      ? rn_dst_new[0] : dst_map[1];
    end
  end

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .AW(AW), .PW(PW)) map_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_arch (rn_src_arch),
    .src_map  (src_map),
    .dst_arch (rn_dst_arch),
    .dst_map  (dst_map),
    .wr_en    (wr_en),
    .wr_phys  (rn_dst_new)
  );

  rn_free_list #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .PW(PW)) fl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pop_cnt   (fire ? need : 2'd0),
    .head      (fl_head),
    .count     (fl_count),
    .push_vld  (cm_valid ? cm_free_vld : '0),
    .push_phys (cm_free_phys)
  );

  // R6
  distinct_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rn_dst_vld == 2'b11) |-> rn_dst_new[0] != rn_dst_new[1]);

  // R3
  new_ne_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && rn_dst_vld[0]) |-> rn_dst_new[0] != rn_dst_old[0]);
endmodule

// File: tb/rename_unit_tb_top.sv
module rename_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rn_valid = 1'b0;
  logic rn_ready;
  logic [2:0][5:0] rn_src_arch = '0;
  logic [2:0]      rn_src_vld = '0;
  logic [1:0][5:0] rn_dst_arch = '0;
  logic [1:0]      rn_dst_vld = '0;
  logic [2:0][5:0] rn_src_phys;
  logic [1:0][5:0] rn_dst_new;
  logic [1:0][5:0] rn_dst_old;
  logic            cm_valid = 1'b0;
  logic [1:0]      cm_free_vld = '0;
  logic [1:0][5:0] cm_free_phys = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rename_unit dut_i (
    .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_ready(rn_ready),
    .rn_src_arch(rn_src_arch), .rn_src_vld(rn_src_vld),
    .rn_dst_arch(rn_dst_arch), .rn_dst_vld(rn_dst_vld),
    .rn_src_phys(rn_src_phys), .rn_dst_new(rn_dst_new), .rn_dst_old(rn_dst_old),
    .cm_valid(cm_valid), .cm_free_vld(cm_free_vld), .cm_free_phys(cm_free_phys)
  );

  typedef struct packed {
    logic [2:0][5:0] sa;
    logic [2:0]      sv;
    logic [1:0][5:0] da;
    logic [1:0]      dv;
    logic [2:0][5:0] es;
    logic [1:0][5:0] en;
    logic [1:0][5:0] eo;
  } vec_t;

  // fields listed slot 2/1 first, slot 0 last
  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    // R1 first allocation is 50, identity map
    '{{6'd0,6'd7,6'd5},   3'b011, {6'd0,6'd3},   2'b01, {6'd0,6'd7,6'd5},    {6'd0,6'd50},  {6'd0,6'd3}},
    // R4 R5 sources see old map, flags register renamed
    '{{6'd3,6'd49,6'd3},  3'b111, {6'd49,6'd3},  2'b11, {6'd50,6'd49,6'd50}, {6'd52,6'd51}, {6'd49,6'd50}},
    // R4 both destinations name the same register
    '{{6'd0,6'd0,6'd10},  3'b001, {6'd10,6'd10}, 2'b11, {6'd0,6'd0,6'd10},   {6'd54,6'd53}, {6'd53,6'd10}},
    // R3 no destinations, reads see earlier updates
    '{{6'd3,6'd10,6'd49}, 3'b111, {6'd0,6'd0},   2'b00, {6'd51,6'd54,6'd52}, {6'd0,6'd0},   {6'd0,6'd0}},
    // R4 only slot 1 valid takes head
    '{{6'd0,6'd49,6'd0},  3'b010, {6'd2,6'd0},   2'b10, {6'd0,6'd52,6'd0},   {6'd55,6'd0},  {6'd2,6'd0}},
    // R5 flags in slot 0, R6 ascending order continues
    '{{6'd0,6'd0,6'd2},   3'b001, {6'd2,6'd49},  2'b11, {6'd0,6'd0,6'd55},   {6'd57,6'd56}, {6'd55,6'd52}}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [2:0][5:0] sa, input logic [2:0] sv,
                       input logic [1:0][5:0] da, input logic [1:0] dv);
    @(negedge clk);
    rn_valid = v; rn_src_arch = sa; rn_src_vld = sv; rn_dst_arch = da; rn_dst_vld = dv;
    cm_valid = 1'b0; cm_free_vld = '0;
    #1;
  endtask

  task automatic commit(input logic v, input logic [1:0] fv, input logic [1:0][5:0] fp);
    @(negedge clk);
    rn_valid = 1'b0; cm_valid = v; cm_free_vld = fv; cm_free_phys = fp;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state: full free list accepts two destinations
    drive(1'b0, '0, '0, {6'd1,6'd0}, 2'b11);
    chk("R1 ready after reset", int'(rn_ready), 1);

    for (int k = 0; k < NV; k++) begin
      drive(1'b1, VEC[k].sa, VEC[k].sv, VEC[k].da, VEC[k].dv);
      chk("R8 ready", int'(rn_ready), 1);
      for (int i = 0; i < 3; i++) chk("R2 src", int'(rn_src_phys[i]), int'(VEC[k].es[i]));
      for (int j = 0; j < 2; j++) begin
        chk("R3 new", int'(rn_dst_new[j]), int'(VEC[k].en[j]));
        chk("R3 old", int'(rn_dst_old[j]), int'(VEC[k].eo[j]));
      end
    end

    // drain remaining 58..63, R6
    drive(1'b1, '0, '0, {6'd21,6'd20}, 2'b11);
    chk("R6 new0", int'(rn_dst_new[0]), 58); chk("R6 new1", int'(rn_dst_new[1]), 59);
    chk("R3 old1", int'(rn_dst_old[1]), 21);
    drive(1'b1, '0, '0, {6'd23,6'd22}, 2'b11);
    chk("R6 new0", int'(rn_dst_new[0]), 60); chk("R6 new1", int'(rn_dst_new[1]), 61);
    drive(1'b1, '0, '0, {6'd0,6'd24}, 2'b01);
    chk("R6 new0", int'(rn_dst_new[0]), 62);
    // one left: two destinations are refused
    drive(1'b1, '0, '0, {6'd26,6'd25}, 2'b11);
    chk("R8 refuse two", int'(rn_ready), 0);
    drive(1'b1, '0, '0, {6'd26,6'd0}, 2'b10);
    chk("R8 accept one", int'(rn_ready), 1);
    chk("R8 refused op took nothing", int'(rn_dst_new[1]), 63);
    chk("R8 refused op kept map", int'(rn_dst_old[1]), 26);
    // empty
    drive(1'b1, '0, '0, {6'd0,6'd27}, 2'b01);
    chk("R8 empty refuses", int'(rn_ready), 0);
    drive(1'b1, {6'd0,6'd0,6'd27}, 3'b001, '0, 2'b00);
    chk("R8 empty accepts no-dest", int'(rn_ready), 1);
    chk("R8 blocked op left map", int'(rn_src_phys[0]), 27);

    // R7 R6 commit two, slot 0 first
    commit(1'b1, 2'b11, {6'd10,6'd3});
    drive(1'b1, '0, '0, {6'd31,6'd30}, 2'b11);
    chk("R7 ready after commit", int'(rn_ready), 1);
    chk("R6 commit order 0", int'(rn_dst_new[0]), 3);
    chk("R6 commit order 1", int'(rn_dst_new[1]), 10);

    // R7 strobe low ignored, then only slot 1 returned
    commit(1'b0, 2'b11, {6'd41,6'd40});
    commit(1'b1, 2'b10, {6'd49,6'd44});
    drive(1'b1, '0, '0, {6'd33,6'd32}, 2'b11);
    chk("R7 ignored commit", int'(rn_ready), 0);
    drive(1'b1, '0, '0, {6'd0,6'd32}, 2'b01);
    chk("R7 slot1 return", int'(rn_dst_new[0]), 49);
    chk("R5 old of 32", int'(rn_dst_old[0]), 32);

    // R8 rn_valid low consumes nothing
    commit(1'b1, 2'b11, {6'd46,6'd45});
    drive(1'b0, '0, '0, {6'd0,6'd34}, 2'b01);
    drive(1'b1, {6'd0,6'd0,6'd34}, 3'b001, {6'd35,6'd34}, 2'b11);
    chk("R8 idle kept map", int'(rn_src_phys[0]), 34);
    chk("R8 idle kept list 0", int'(rn_dst_new[0]), 45);
    chk("R8 idle kept list 1", int'(rn_dst_new[1]), 46);
    drive(1'b0, '0, '0, '0, 2'b00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule